// File: doc/BRIEF.md
# Key-Sequenced Watchdog Reset Controller

This block turns a 64-bit up-counter into a watchdog that can only be armed by a fixed unlock ritual. Software first selects watchdog operation in a global mode register and releases both counter halves from reset. It then loads the counter and the period, which may be zero. Finally it writes two 16-bit keys, in order, into a control register, with the enable bit set on the first of them. Once armed, the counter advances on every clock. Software must keep repeating the same two-key pair to clear the counter before it reaches the period.

If the counter reaches the period, or software writes any key other than the one the sequence expects, the block raises a system reset request. The request stays high until the block's own reset input is applied. Every register write goes through one simple write strobe, address and data bus. The current state, the stored enable bit and the live count are visible on status outputs.

Top module: `wdk_top`

## Requirements
- R1: After a synchronous active-low reset, the state is 0 (idle), `rst_req` is 0, `wd_en` is 0, and the count, the period and the mode register are all 0.
- R2: Arming from idle happens only while the mode register (address 0) holds 2 in bits 3:2 and both run bits (bit 1 and bit 0) are 1, i.e. the value 0xB. With any other mode value, key writes leave the state at 0.
- R3: In idle, a write to the control register (address 5) with bit 14 = 1 and key field bits 31:16 = 0xA5C6 moves the state to 1 (pre-armed). Every control write made in idle stores bit 14 as `wd_en`.
- R4: In pre-armed, key 0xDA7E moves the state to 2 (armed). In idle and pre-armed, all other key values are ignored and the state stays put.
- R5: In armed, key 0xA5C6 moves the state to 3 (servicing). In servicing, key 0xDA7E returns the state to 2 and clears the count to 0.
- R6: In armed or servicing, a control write carrying any key other than the expected one moves the state to 4 (tripped) on that clock edge, which raises `rst_req`.
- R7: In armed or servicing, the count increases by one per clock. At the edge where the count equals the period, the state becomes 4 instead. A zero period therefore trips one clock after arming.
- R8: Counter words (addresses 1 = low, 2 = high), period words (addresses 3 = low, 4 = high) and the mode register accept writes only in idle. In every other state these writes are ignored.
- R9: In armed and servicing, the enable bit of a control write is ignored and `wd_en` stays 1. Only the key decides the transition.
- R10: Once `rst_req` is 1, it and state 4 persist, whatever is written, until `rst_n` is low at a clock edge.
- R11: In idle and pre-armed, the count changes only through software writes. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Register address: 0 mode, 1-2 count, 3-4 period, 5 control |
| wr_data | input | 32 | Write data |
| rst_req | output | 1 | System reset request, sticky |
| wd_state | output | 3 | State code: 0 idle, 1 pre-armed, 2 armed, 3 servicing, 4 tripped |
| wd_en | output | 1 | Stored enable bit |
| count | output | 64 | Current counter value |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any check applies. They also assume that `wr_en` is the only input that can change the count outside the armed states, so a held count is checked only in cycles without a write. The stimulus drives every input on the falling edge and holds one write per cycle. It starts with reset asserted and reapplies reset before each independent scenario, so every transition it exercises begins from the documented reset state.

// File: rtl/wdk_pkg.sv
// Package: shared constants and the state type of the key-sequenced watchdog.
// Assumes a 32-bit register data bus and a 16-bit key field in the upper half
// of the control word.
package wdk_pkg;

    localparam int DATA_W  = 32;
    localparam int KEY_W   = 16;
    localparam int KEY_LSB = 16;
    localparam int EN_BIT  = 14;

    localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6;
    localparam logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E;

    localparam logic [1:0] MODE_WDOG = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PRE     = 3'd1,
        ST_ACTIVE  = 3'd2,
        ST_SERVICE = 3'd3,
        ST_TRIPPED = 3'd4
    } wd_state_e;

endpackage

// File: rtl/wdk_cfg.sv
// Module: configuration registers (mode register and multi-word period).
// Assumes writes are accepted only while cfg_open is high; the owner drives
// cfg_open from the idle state so settings freeze once arming starts.
module wdk_cfg #(
    parameter int DATA_W   = 32,
    parameter int NWORDS   = 2,
    parameter int ADDR_W   = 3,
    parameter int MODE_ADR = 0,
    parameter int PRD_BASE = 3,
    localparam int CNT_W   = DATA_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_open,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  period,
    output logic              wd_mode
);

    logic [3:0] mode_q;
    logic [NWORDS-1:0][DATA_W-1:0] prd_q;

    // Mode register: timer mode in bits 3:2, half run bits in 1:0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (cfg_open && wr_en && wr_addr == ADDR_W'(MODE_ADR)) begin
            mode_q <= wr_data[3:0];
        end
    end

    // One register per period word, each with its own address.
    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_prd
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prd_q[gi] <= '0;
            end else if (cfg_open && wr_en && wr_addr == ADDR_W'(PRD_BASE + gi)) begin
                prd_q[gi] <= wr_data;
            end
        end
    end

    assign period  = prd_q;
    assign wd_mode = (mode_q[3:2] == wdk_pkg::MODE_WDOG) && (mode_q[1:0] == 2'b11);

endmodule

// File: rtl/wdk_counter.sv
// Module: wide up-counter with per-word software load, clear and increment.
// Assumes clear and increment never coincide with load_open.
module wdk_counter #(
    parameter int DATA_W   = 32,
    parameter int NWORDS   = 2,
    parameter int ADDR_W   = 3,
    parameter int CNT_BASE = 1,
    localparam int CNT_W   = DATA_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_open,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic              inc,
    output logic [CNT_W-1:0]  count
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count: clear beats increment; a software word write overrides its slice.
    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
        for (int i = 0; i < NWORDS; i++) begin
            if (load_open && wr_en && wr_addr == ADDR_W'(CNT_BASE + i)) begin
                cnt_d[i*DATA_W +: DATA_W] = wr_data;
            end
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/wdk_fsm.sv
// Module: arming, servicing and trip state machine of the watchdog.
// Assumes key_wr marks one control-register write and that expire is only
// meaningful while armed or servicing.
module wdk_fsm
    import wdk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key,
    input  logic             en_bit,
    input  logic             wd_mode,
    input  logic             expire,
    output wd_state_e        state,
    output logic             en_q,
    output logic             clr_cnt,
    output logic             inc_cnt
);

    wd_state_e state_d;
    logic      armed;

    assign armed = (state == ST_ACTIVE) || (state == ST_SERVICE);

    // Next-state decode: ordered unlock, service pair, trip on wrong key or expiry.
    always_comb begin
        state_d = state;
        clr_cnt = 1'b0;
        case (state)
            ST_IDLE: begin
                if (key_wr && en_bit && wd_mode && key == KEY_FIRST) begin
                    state_d = ST_PRE;
                end
            end
            ST_PRE: begin
                if (key_wr && key == KEY_SECOND) begin
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (expire) begin
                    state_d = ST_TRIPPED;
                end else if (key_wr) begin
                    state_d = (key == KEY_FIRST) ? ST_SERVICE : ST_TRIPPED;
                end
            end
            ST_SERVICE: begin
                if (expire) begin
                    state_d = ST_TRIPPED;
                end else if (key_wr) begin
                    if (key == KEY_SECOND) begin
                        state_d = ST_ACTIVE;
                        clr_cnt = 1'b1;
                    end else begin
                        state_d = ST_TRIPPED;
                    end
                end
            end
            ST_TRIPPED: state_d = ST_TRIPPED;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign inc_cnt = armed && !expire;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Enable bit: writable only in idle, frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (state == ST_IDLE && key_wr) begin
            en_q <= en_bit;
        end
    end

endmodule

// File: rtl/wdk_top.sv
// Module: key-sequenced watchdog top. Decodes the write bus, compares the
// count with the period and drives the sticky reset request.
// Assumes at most one register write per cycle.
module wdk_top #(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [wdk_pkg::DATA_W-1:0] wr_data,
    output logic                       rst_req,
    output logic [2:0]                 wd_state,
    output logic                       wd_en,
    output logic [CNT_W-1:0]           count
);
    import wdk_pkg::*;

    localparam int NWORDS   = CNT_W / DATA_W;
    localparam int MODE_ADR = 0;
    localparam int CNT_BASE = MODE_ADR + 1;
    localparam int PRD_BASE = CNT_BASE + NWORDS;
    localparam int CTL_ADR  = PRD_BASE + NWORDS;

    wd_state_e        state;
    logic [CNT_W-1:0] period;
    logic             wd_mode;
    logic             key_wr;
    logic             cfg_open;
    logic             expire;
    logic             clr_cnt;
    logic             inc_cnt;

    assign cfg_open = (state == ST_IDLE);
    assign key_wr   = wr_en && (wr_addr == ADDR_W'(CTL_ADR));
    assign expire   = ((state == ST_ACTIVE) || (state == ST_SERVICE)) && (count == period);

    wdk_cfg #(
        .DATA_W(DATA_W), .NWORDS(NWORDS), .ADDR_W(ADDR_W),
        .MODE_ADR(MODE_ADR), .PRD_BASE(PRD_BASE)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_open(cfg_open), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .period(period), .wd_mode(wd_mode)
    );

    wdk_counter #(
        .DATA_W(DATA_W), .NWORDS(NWORDS), .ADDR_W(ADDR_W), .CNT_BASE(CNT_BASE)
    ) cnt_i (
        .clk(clk), .rst_n(rst_n), .load_open(cfg_open), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .clr(clr_cnt), .inc(inc_cnt),
        .count(count)
    );

    wdk_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
        .key(wr_data[KEY_LSB +: KEY_W]), .en_bit(wr_data[EN_BIT]),
        .wd_mode(wd_mode), .expire(expire), .state(state), .en_q(wd_en),
        .clr_cnt(clr_cnt), .inc_cnt(inc_cnt)
    );

    assign rst_req  = (state == ST_TRIPPED);
    assign wd_state = state;

endmodule

// File: rtl/wdk_checker.sv
// Module: temporal checks on the watchdog ports, bound into wdk_top.
// Assumes reset is held low for at least one edge at start-up.
module wdk_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rst_req,
    input logic [2:0]       wd_state,
    input logic             wd_en,
    input logic [CNT_W-1:0] count
);
    import wdk_pkg::*;

    logic st_armed;
    assign st_armed = (wd_state == ST_ACTIVE) || (wd_state == ST_SERVICE);

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req); // R10

    AST_TRIP_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(wd_state) == ST_ACTIVE || $past(wd_state) == ST_SERVICE)); // R6

    AST_ARMED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_state == ST_ACTIVE) |-> ($past(wd_state) == ST_PRE || $past(wd_state) == ST_ACTIVE
                                     || $past(wd_state) == ST_SERVICE)); // R4

    AST_PRE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_state == ST_PRE) |-> ($past(wd_state) == ST_IDLE || $past(wd_state) == ST_PRE)); // R3

    AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        st_armed |-> wd_en); // R9

    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((wd_state == ST_IDLE || wd_state == ST_PRE) && !wr_en) |=> $stable(count)); // R11

endmodule

bind wdk_top wdk_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rst_req(rst_req),
    .wd_state(wd_state), .wd_en(wd_en), .count(count)
);

// File: tb/wdk_top_tb_top.sv
`timescale 1ns/1ps
module wdk_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rst_req;
    logic [2:0]  wd_state;
    logic        wd_en;
    logic [63:0] count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdk_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rst_req(rst_req), .wd_state(wd_state),
        .wd_en(wd_en), .count(count)
    );

    // Rows: addr[37:35], data[34:3], expected state[2:0]
    localparam int NV = 11;
    localparam logic [37:0] VECS [0:NV-1] = '{
        {3'd0, 32'h0000_000B, 3'd0},
        {3'd3, 32'h0000_03E8, 3'd0},
        {3'd4, 32'h0000_0000, 3'd0},
        {3'd1, 32'h0000_0000, 3'd0},
        {3'd5, 32'hDA7E_4000, 3'd0},
        {3'd5, 32'hA5C6_0000, 3'd0},
        {3'd5, 32'hA5C6_4000, 3'd1},
        {3'd5, 32'h1234_4000, 3'd1},
        {3'd5, 32'hDA7E_4000, 3'd2},
        {3'd5, 32'hA5C6_4000, 3'd3},
        {3'd5, 32'hDA7E_4000, 3'd2}
    };

    function automatic string row_tag(int i);
        if (i < 4)      return "R8";
        else if (i == 4 || i == 7 || i == 8) return "R4";
        else if (i < 7) return "R3";
        else            return "R5";
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write captured at the next rising edge; returns at the following falling edge.
    task automatic wr(logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic chk_reset_state();
        chk("R1 state", 64'(wd_state), 64'd0);
        chk("R1 rst_req", 64'(rst_req), 64'd0);
        chk("R1 wd_en", 64'(wd_en), 64'd0);
        chk("R1 count", count, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk_reset_state();

        // Table walk: configure, ordered unlock, one service pair.
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i][37:35], VECS[i][34:3]);
            chk(row_tag(i), 64'(wd_state), 64'(VECS[i][2:0]));
            chk(row_tag(i), 64'(rst_req), 64'd0);
        end
        chk("R5 count cleared", count, 64'd0);

        // Locked registers while armed (R8), enable ignored (R9).
        wr(3'd1, 32'h0000_0100);
        chk("R8 count not loaded", count, 64'd1);
        wr(3'd0, 32'h0000_0000);
        chk("R8 mode locked", 64'(wd_state), 64'd2);
        chk("R7 count advancing", count, 64'd2);
        wr(3'd5, 32'hA5C6_0000);
        chk("R9 service without enable", 64'(wd_state), 64'd3);
        chk("R9 wd_en held", 64'(wd_en), 64'd1);
        wr(3'd5, 32'h0000_4000);
        chk("R6 bad key trips", 64'(rst_req), 64'd1);
        chk("R6 state", 64'(wd_state), 64'd4);
        wr(3'd5, 32'hDA7E_4000);
        chk("R10 sticky after key", 64'(wd_state), 64'd4);
        idle(3);
        chk("R10 sticky after idle", 64'(rst_req), 64'd1);

        do_reset();
        chk_reset_state();

        // Counter load and hold in idle.
        wr(3'd1, 32'h0000_0007);
        wr(3'd2, 32'h0000_0001);
        chk("R8 count load", count, 64'h0000_0001_0000_0007);
        idle(2);
        chk("R11 count held", count, 64'h0000_0001_0000_0007);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h0);

        // Mode qualification.
        wr(3'd0, 32'h0000_0007);
        wr(3'd5, 32'hA5C6_4000);
        chk("R2 wrong mode", 64'(wd_state), 64'd0);
        wr(3'd0, 32'h0000_0009);
        wr(3'd5, 32'hA5C6_4000);
        chk("R2 half in reset", 64'(wd_state), 64'd0);
        wr(3'd0, 32'h0000_000B);
        wr(3'd5, 32'hA5C6_4000);
        chk("R2 watchdog mode", 64'(wd_state), 64'd1);
        idle(2);
        chk("R11 held in pre-armed", count, 64'd0);

        // Zero period trips one clock after arming.
        wr(3'd5, 32'hDA7E_4000);
        chk("R7 zero period armed", 64'(rst_req), 64'd0);
        idle(1);
        chk("R7 zero period trip", 64'(rst_req), 64'd1);

        // Expiry with period 5.
        do_reset();
        wr(3'd0, 32'h0000_000B);
        wr(3'd3, 32'h0000_0005);
        wr(3'd5, 32'hA5C6_4000);
        wr(3'd5, 32'hDA7E_4000);
        chk("R7 armed count", count, 64'd0);
        idle(5);
        chk("R7 count at period", count, 64'd5);
        chk("R7 not yet tripped", 64'(rst_req), 64'd0);
        idle(1);
        chk("R7 expiry trip", 64'(rst_req), 64'd1);
        chk("R7 state tripped", 64'(wd_state), 64'd4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule